// File: doc/BRIEF.md
# Dual-Write Register File with Deferred Second Write

This block is a register file that takes up to two writes per cycle while its storage array has a single write port. The primary write goes into the array at the next clock edge. When a secondary write to a different address arrives in the same cycle, it is held in a one-entry side buffer and copied into the array on the following cycle.

If the caller presents any write while that copy is due, the block raises a stall in the same cycle. The presented writes are then discarded, and the caller issues them again on the next cycle. Three combinational read ports return array contents. When a read address matches the pending buffered entry, the buffered word is returned instead.

Dual writes are expected to be rare, so the occasional stall costs little. Callers must honour the stall by repeating the writes it rejected.

Top module: `dual_write_rf`

## Requirements
- R1: After reset every register reads as zero on all read ports, the stall output is low and no buffered entry is pending.
- R2: A write presented alone on either the primary or the secondary port, with no stall, is returned by every read port from the cycle after the clock edge. Before that edge, reads return the old value.
- R3: A dual write to two different addresses, with no stall, makes both values readable from the cycle after the edge.
- R4: The secondary value of such a dual write is committed to the array during the following cycle. No stall is raised if that cycle carries no write, and the value stays readable afterwards.
- R5: The stall output is high in a cycle exactly when the previous cycle accepted a dual write to two different addresses and the current cycle presents a write on either port. It is a combinational function of the current write enables.
- R6: Writes presented in a stalled cycle have no effect on any register. The cycle after a stall never stalls.
- R7: When both ports write the same address in one accepted cycle, the secondary data is stored, nothing is buffered, and the next cycle does not stall.
- R8: A write reissued after a stall to the address that was buffered wins. Later reads return the reissued value.
- R9: Read data is combinational in the read address. When an address matches the pending buffered entry, the buffered data is returned. The three ports are independent and may use any addresses, including equal ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wa_en | input | 1 | Primary write enable |
| wa_addr | input | ADDR_W | Primary write address |
| wa_data | input | DATA_W | Primary write data |
| wb_en | input | 1 | Secondary write enable |
| wb_addr | input | ADDR_W | Secondary write address |
| wb_data | input | DATA_W | Secondary write data |
| rd_addr | input | NUM_RD*ADDR_W | Read addresses, port i in bits [i*ADDR_W +: ADDR_W] |
| rd_data | output | NUM_RD*DATA_W | Read data, port i in bits [i*DATA_W +: DATA_W] |
| stall | output | 1 | High when this cycle's writes are rejected so the buffered write can drain |

## Verification
Stall and read data settle within the same cycle as their inputs. Accepted writes become visible one clock edge later, whether they were written directly or held in the buffer. The bench drives each cycle's inputs on the falling edge and samples stall and all three read ports one time unit later. It compares them against a reference array and a pending flag. The reference is updated only after the rising edge, and only when the expected stall is low. A read that overlaps a write therefore checks the old value, and the next cycle checks the new one.

// File: rtl/dwrf_pkg.sv
package dwrf_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_PRI  = 2'd1,
      SRC_SEC  = 2'd2,
      SRC_BUF  = 2'd3
   } wsrc_e;
endpackage

// File: rtl/dwrf_array.sv
module dwrf_array #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 5,
   parameter int NUM_RD = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [ADDR_W-1:0]          waddr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [NUM_RD*ADDR_W-1:0]   raddr,
   output logic [NUM_RD*DATA_W-1:0]   rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      assign rdata[p*DATA_W +: DATA_W] = mem[raddr[p*ADDR_W +: ADDR_W]];
   end
endmodule

// File: rtl/dwrf_ctrl.sv
module dwrf_ctrl
   import dwrf_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wa_en,
   input  logic [ADDR_W-1:0] wa_addr,
   input  logic [DATA_W-1:0] wa_data,
   input  logic              wb_en,
   input  logic [ADDR_W-1:0] wb_addr,
   input  logic [DATA_W-1:0] wb_data,
   output logic              stall,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_waddr,
   output logic [DATA_W-1:0] arr_wdata,
   output logic              buf_vld,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [DATA_W-1:0] buf_data
);
   wsrc_e src;
   logic  split;
   logic  load;

   // Dual write to distinct addresses needs the buffer.
   assign split = wa_en & wb_en & (wa_addr != wb_addr);
   assign stall = buf_vld & (wa_en | wb_en);
   assign load  = ~buf_vld & split;

   always_comb begin
      if (buf_vld)                 src = SRC_BUF;
      else if (wb_en && !split)    src = SRC_SEC;
      else if (wa_en)              src = SRC_PRI;
      else                         src = SRC_NONE;
   end

   always_comb begin
      arr_we    = 1'b1;
      arr_waddr = '0;
      arr_wdata = '0;
      unique case (src)
         SRC_BUF: begin arr_waddr = buf_addr; arr_wdata = buf_data; end
         SRC_SEC: begin arr_waddr = wb_addr;  arr_wdata = wb_data;  end
         SRC_PRI: begin arr_waddr = wa_addr;  arr_wdata = wa_data;  end
         default: arr_we = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_vld  <= 1'b0;
         buf_addr <= '0;
         buf_data <= '0;
      end else begin
         buf_vld <= load;
         if (load) begin
            buf_addr <= wb_addr;
            buf_data <= wb_data;
         end
      end
   end
endmodule

// File: rtl/dwrf_bypass.sv
module dwrf_bypass #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 5,
   parameter int NUM_RD = 3
) (
   input  logic [NUM_RD*ADDR_W-1:0] raddr,
   input  logic [NUM_RD*DATA_W-1:0] arr_rdata,
   input  logic                     buf_vld,
   input  logic [ADDR_W-1:0]        buf_addr,
   input  logic [DATA_W-1:0]        buf_data,
   output logic [NUM_RD*DATA_W-1:0] rdata
);
   for (genvar p = 0; p < NUM_RD; p++) begin : g_byp
      logic hit;
      assign hit = buf_vld & (raddr[p*ADDR_W +: ADDR_W] == buf_addr);
      assign rdata[p*DATA_W +: DATA_W] = hit ? buf_data : arr_rdata[p*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/dual_write_rf.sv
module dual_write_rf #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 5,
   parameter int NUM_RD = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wa_en,
   input  logic [ADDR_W-1:0]        wa_addr,
   input  logic [DATA_W-1:0]        wa_data,
   input  logic                     wb_en,
   input  logic [ADDR_W-1:0]        wb_addr,
   input  logic [DATA_W-1:0]        wb_data,
   input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
   output logic [NUM_RD*DATA_W-1:0] rd_data,
   output logic                     stall
);
   if (DATA_W < 1) begin : g_bad_data
      $error("dual_write_rf: DATA_W must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("dual_write_rf: ADDR_W must be within 1..10");
   end
   if (NUM_RD < 1) begin : g_bad_rd
      $error("dual_write_rf: NUM_RD must be at least 1");
   end

   logic              arr_we;
   logic [ADDR_W-1:0] arr_waddr;
   logic [DATA_W-1:0] arr_wdata;
   logic              buf_vld;
   logic [ADDR_W-1:0] buf_addr;
   logic [DATA_W-1:0] buf_data;
   logic [NUM_RD*DATA_W-1:0] arr_rdata;

   dwrf_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
      .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
      .stall(stall),
      .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
      .buf_vld(buf_vld), .buf_addr(buf_addr), .buf_data(buf_data)
   );

   dwrf_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_RD(NUM_RD)) u_array (
      .clk(clk), .rst_n(rst_n),
      .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
      .raddr(rd_addr), .rdata(arr_rdata)
   );

   dwrf_bypass #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_RD(NUM_RD)) u_bypass (
      .raddr(rd_addr), .arr_rdata(arr_rdata),
      .buf_vld(buf_vld), .buf_addr(buf_addr), .buf_data(buf_data),
      .rdata(rd_data)
   );
endmodule

// File: rtl/dual_write_rf_chk.sv
module dual_write_rf_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 5,
   parameter int NUM_RD = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wa_en,
   input logic [ADDR_W-1:0]        wa_addr,
   input logic                     wb_en,
   input logic [ADDR_W-1:0]        wb_addr,
   input logic                     stall,
   input logic [NUM_RD*ADDR_W-1:0] rd_addr,
   input logic [NUM_RD*DATA_W-1:0] rd_data,
   input logic                     buf_vld,
   input logic [ADDR_W-1:0]        buf_addr,
   input logic [DATA_W-1:0]        buf_data
);
   logic split_ok;
   logic same_ok;
   assign split_ok = rst_n && wa_en && wb_en && (wa_addr != wb_addr) && !stall;
   assign same_ok  = rst_n && wa_en && wb_en && (wa_addr == wb_addr) && !stall;

   // R5
   stall_required_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(split_ok) && (wa_en || wb_en)) |-> stall);

   // R5
   stall_justified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> $past(split_ok));

   // R6
   no_back_to_back_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall);

   // R7
   same_addr_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(same_ok) |-> !stall);

   // R4
   buffer_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_vld |=> !buf_vld);

   for (genvar p = 0; p < NUM_RD; p++) begin : g_byp_chk
      // R9
      bypass_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (buf_vld && rd_addr[p*ADDR_W +: ADDR_W] == buf_addr)
            |-> rd_data[p*DATA_W +: DATA_W] == buf_data);
   end
endmodule

bind dual_write_rf dual_write_rf_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_RD(NUM_RD)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .wa_en(wa_en), .wa_addr(wa_addr), .wb_en(wb_en), .wb_addr(wb_addr),
   .stall(stall), .rd_addr(rd_addr), .rd_data(rd_data),
   .buf_vld(buf_vld), .buf_addr(buf_addr), .buf_data(buf_data)
);

// File: tb/dual_write_rf_tb.sv
module dual_write_rf_tb;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 5;
   localparam int NUM_RD = 3;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam time CLK_PERIOD = 10;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     wa_en = 1'b0, wb_en = 1'b0;
   logic [ADDR_W-1:0]        wa_addr = '0, wb_addr = '0;
   logic [DATA_W-1:0]        wa_data = '0, wb_data = '0;
   logic [NUM_RD*ADDR_W-1:0] rd_addr = '0;
   logic [NUM_RD*DATA_W-1:0] rd_data;
   logic                     stall;

   int n_checks = 0;
   int n_fail   = 0;
   logic [DATA_W-1:0] ref_mem [DEPTH];
   bit pend = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_write_rf #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_RD(NUM_RD)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
      .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .stall(stall)
   );

   function automatic bit exp_stall(bit p, bit a_en, bit b_en);
      return p && (a_en || b_en);
   endfunction

   task automatic check(string tag, string what, longint act, longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic step(string tag,
                       bit a_en, int a_ad, int a_d,
                       bit b_en, int b_ad, int b_d,
                       int r0, int r1, int r2);
      bit es;
      int ra [NUM_RD];
      ra[0] = r0; ra[1] = r1; ra[2] = r2;
      @(negedge clk);
      wa_en = a_en; wa_addr = ADDR_W'(a_ad); wa_data = DATA_W'(a_d);
      wb_en = b_en; wb_addr = ADDR_W'(b_ad); wb_data = DATA_W'(b_d);
      for (int p = 0; p < NUM_RD; p++) rd_addr[p*ADDR_W +: ADDR_W] = ADDR_W'(ra[p]);
      #1;
      es = exp_stall(pend, a_en, b_en);
      check(tag, "stall", longint'(stall), longint'(es));
      for (int p = 0; p < NUM_RD; p++)
         check(tag, $sformatf("rd%0d @%0d", p, ra[p]),
               longint'(rd_data[p*DATA_W +: DATA_W]), longint'(ref_mem[ra[p]]));
      @(posedge clk);
      #1;
      if (!es) begin
         if (a_en) ref_mem[ADDR_W'(a_ad)] = DATA_W'(a_d);
         if (b_en) ref_mem[ADDR_W'(b_ad)] = DATA_W'(b_d);
      end
      pend = !es && a_en && b_en && (ADDR_W'(a_ad) != ADDR_W'(b_ad));
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED_0042);
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
      #(CLK_PERIOD * 3);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents and stall
      step("R1", 0,0,0, 0,0,0, 0, 1, 31);
      // R2: single writes on either port, old value in the write cycle
      step("R2", 1,3,16'hA1A1, 0,0,0, 3, 4, 0);
      step("R2", 0,0,0, 1,4,16'hB2B2, 3, 4, 3);
      step("R2", 0,0,0, 0,0,0, 4, 3, 4);
      // R3: dual write to distinct addresses
      step("R3", 1,5,16'hC1C1, 1,6,16'hC2C2, 5, 6, 0);
      // R4 / R9: drain cycle without write, secondary via bypass
      step("R4", 0,0,0, 0,0,0, 5, 6, 6);
      step("R4", 0,0,0, 0,0,0, 6, 5, 6);
      // R5: write right after a dual write stalls
      step("R5", 1,7,16'h0707, 1,8,16'h0808, 0, 0, 0);
      step("R5", 1,9,16'h0909, 0,0,0, 7, 8, 9);
      // R6: stalled write had no effect, no second stall
      step("R6", 0,0,0, 1,9,16'h1111, 9, 8, 7);
      step("R6", 0,0,0, 0,0,0, 9, 9, 9);
      // R7: same address, secondary wins, no later stall
      step("R7", 1,10,16'h0111, 1,10,16'h0222, 10, 10, 10);
      step("R7", 1,11,16'h0333, 0,0,0, 10, 11, 0);
      step("R7", 0,0,0, 0,0,0, 10, 11, 10);
      // R8: reissued write to the buffered address wins
      step("R8", 1,12,16'hD1D1, 1,13,16'hD2D2, 12, 13, 0);
      step("R8", 1,13,16'hE1E1, 0,0,0, 13, 12, 13);
      step("R8", 1,13,16'hE1E1, 0,0,0, 13, 13, 12);
      step("R8", 0,0,0, 0,0,0, 13, 12, 13);

      // R9: random mixed traffic with collisions on a narrow address range
      for (int k = 0; k < 3000; k++) begin
         bit ae, be;
         ae = ($urandom % 100) < 50;
         be = ($urandom % 100) < 30;
         step("R9", ae, $urandom % 8, $urandom % 65536,
                    be, $urandom % 8, $urandom % 65536,
                    $urandom % 8, $urandom % 8, $urandom % 8);
      end
      step("R9", 0,0,0, 0,0,0, 0, 1, 2);
      summary();
   end
endmodule